// File: doc/BRIEF.md
# Programmable Down-Counter Timer

This block is a single down-counting timer that software reaches through a small word-addressed register bus. The count is clocked by the system clock through a prescaler. It can run as a free-running wrapper, as a periodic reloader or as a one-shot, and it can be 16 or 32 bits wide. When the count reaches zero, a sticky flag is set. That flag, gated by an enable bit, drives a level interrupt line.

Software loads a limit in one of two ways. One write restarts the count at once. The other write leaves the count alone and takes effect at the next natural reload. Status can be read before the enable mask (raw) and after it (masked), and a write to a dedicated clear slot drops the flag. The asynchronous reset is released on a clock edge inside the block.

Top module: `dtm_timer`

## Requirements
- R1: After reset the control register reads 0x20, and the count, the stored limit, raw status and `irq` all read 0.
- R2: Register byte addresses are word index times 4: 0x00 immediate load, 0x04 count (read-only), 0x08 control, 0x0C flag clear, 0x10 raw status, 0x14 masked status, 0x18 deferred load. An address with nonzero bits 1:0, or with any other index, reads 0 and ignores writes. A write to 0x04 changes nothing. Control reads back bits 7:0 of the last write, with the upper bits reading 0.
- R3: Control bits 3:2 choose the prescale: 0 or 3 decrements on every clock, 1 on every 16th, 2 on every 256th. Every control write restarts the prescaler, so the first decrement lands N clocks after that write.
- R4: `irq` and masked status equal raw status ANDed with control bit 5. Both are 0 while bit 5 is clear.
- R5: Any write to 0x0C clears raw status. If the count reaches zero in the same cycle, the flag is set instead.
- R6: Raw status is set on the decrement that takes a nonzero count to zero.
- R7: One-shot mode (bit 0 set) holds the count at zero after it is reached, with no further flag events, until a new reload.
- R8: Periodic mode (bit 6 set, bit 0 clear) reloads the stored limit on the decrement after zero.
- R9: Free-running mode (bits 0 and 6 both clear) reloads 0xFFFF in 16-bit mode or 0xFFFFFFFF in 32-bit mode, both at zero and on any reload, and ignores the limit.
- R10: A write to 0x00 stores the limit and reloads the count in the next cycle, regardless of enable.
- R11: A write to 0x18 stores the limit without touching the count. Reads of 0x00 and 0x18 return the same value.
- R12: A control write with bit 7 set reloads the count. While bit 7 is clear the count is frozen.
- R13: With bit 1 clear (16-bit), only the low 16 bits count and bits 31:16 of the count read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions take three things for granted. A write lasts exactly one clock. The address is stable while the write strobe is high. No mode change and reload race at the same edge as an expected zero crossing, except where the collision rule itself is the subject.

The directed stimulus keeps within these limits. It drives every write for one cycle from the falling edge. Control writes are issued while the timer is disabled, or together with bit 7 so that they force a reload. The flag is cleared only at points where the bench has already computed that no zero crossing is pending.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

  // control register layout, MSB first
  typedef struct packed {
    logic       enable;    // bit 7
    logic       periodic;  // bit 6
    logic       ie;        // bit 5
    logic       spare;     // bit 4
    logic [1:0] psel;      // bits 3:2
    logic       wide;      // bit 1
    logic       oneshot;   // bit 0
  } ctrl_t;

  localparam int unsigned CTRL_W   = $bits(ctrl_t);
  localparam ctrl_t       CTRL_RST = 8'h20;

  // word indices of the register slots
  localparam int unsigned IDX_LOAD   = 0;
  localparam int unsigned IDX_VALUE  = 1;
  localparam int unsigned IDX_CTRL   = 2;
  localparam int unsigned IDX_CLEAR  = 3;
  localparam int unsigned IDX_RAW    = 4;
  localparam int unsigned IDX_MASKED = 5;
  localparam int unsigned IDX_BGLOAD = 6;

endpackage

// File: rtl/dtm_rst_sync.sv
module dtm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/dtm_prescaler.sv
module dtm_prescaler #(
  parameter int unsigned SHIFT_A = 4,
  parameter int unsigned SHIFT_B = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] psel,
  output logic       tick
);

  logic [SHIFT_B-1:0] pre_q;
  logic [SHIFT_B-1:0] pre_d;
  logic               pre_en;

  always_comb begin
    pre_en = restart | run;
    pre_d  = restart ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

  always_comb begin
    unique case (psel)
      2'd1:    tick = run & (&pre_q[SHIFT_A-1:0]);
      2'd2:    tick = run & (&pre_q);
      default: tick = run;
    endcase
  end

  // R3: a divide-by-256 tick is never followed by another tick at once
  a_r3_div_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && psel == 2'd2) |=> (!tick || psel == 2'd0 || psel == 2'd3));

endmodule

// File: rtl/dtm_counter.sv
module dtm_counter #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned NARROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_req,
  input  logic             wide,
  input  logic             oneshot,
  input  logic             free_run,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt_view,
  output logic             zero_evt
);

  localparam logic [CNT_W-1:0] MASK_WIDE   = '1;
  localparam logic [CNT_W-1:0] MASK_NARROW = CNT_W'({NARROW_W{1'b1}});

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] reload_val;

  always_comb begin
    mask       = wide ? MASK_WIDE : MASK_NARROW;
    cnt_view   = cnt_q & mask;
    reload_val = free_run ? mask : (limit & mask);
  end

  always_comb begin
    cnt_d    = cnt_q;
    zero_evt = 1'b0;
    cnt_en   = load_req | tick;
    if (load_req) begin
      cnt_d = reload_val;
    end else if (tick) begin
      if (cnt_view == '0) begin
        if (!oneshot) cnt_d = reload_val;
      end else begin
        cnt_d    = (cnt_view - 1'b1) & mask;
        zero_evt = (cnt_view == CNT_W'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R7: a one-shot count at zero stays put on further ticks
  a_r7_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_req && oneshot && cnt_view == '0) |=> $stable(cnt_q));

  // R13: a reload in 16-bit mode leaves the upper bits clear
  a_r13_narrow_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !wide) |=> (cnt_q[CNT_W-1:NARROW_W] == '0));

endmodule

// File: rtl/dtm_regs.sv
module dtm_regs
  import dtm_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  cnt_view,
  input  logic              zero_evt,
  output ctrl_t             ctrl_q,
  output ctrl_t             ctrl_d,
  output logic [CNT_W-1:0]  limit_d,
  output logic              ctrl_we,
  output logic              load_req,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic sel_load, sel_val, sel_ctrl, sel_clr, sel_raw, sel_mis, sel_bg;
  logic load_we, bg_we, clr_we, limit_we;
  logic [CNT_W-1:0] limit_q;
  logic raw_q, raw_d, raw_en;

  always_comb begin
    idx      = bus_addr[ADDR_W-1:2];
    aligned  = (bus_addr[1:0] == 2'b00);
    sel_load = aligned && (idx == IDX_W'(IDX_LOAD));
    sel_val  = aligned && (idx == IDX_W'(IDX_VALUE));
    sel_ctrl = aligned && (idx == IDX_W'(IDX_CTRL));
    sel_clr  = aligned && (idx == IDX_W'(IDX_CLEAR));
    sel_raw  = aligned && (idx == IDX_W'(IDX_RAW));
    sel_mis  = aligned && (idx == IDX_W'(IDX_MASKED));
    sel_bg   = aligned && (idx == IDX_W'(IDX_BGLOAD));
  end

  always_comb begin
    load_we  = bus_we & sel_load;
    bg_we    = bus_we & sel_bg;
    ctrl_we  = bus_we & sel_ctrl;
    clr_we   = bus_we & sel_clr;
    limit_we = load_we | bg_we;
    load_req = load_we | (ctrl_we & bus_wdata[CTRL_W-1]);
  end

  // next state
  always_comb begin
    ctrl_d  = ctrl_we  ? ctrl_t'(bus_wdata[CTRL_W-1:0]) : ctrl_q;
    limit_d = limit_we ? bus_wdata : limit_q;
    raw_en  = zero_evt | clr_we;
    raw_d   = zero_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RST;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        limit_q <= '0;
    else if (limit_we) limit_q <= limit_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw_q <= 1'b0;
    else if (raw_en) raw_q <= raw_d;
  end

  assign irq = raw_q & ctrl_q.ie;

  always_comb begin
    bus_rdata = '0;
    if (sel_load || sel_bg) bus_rdata = limit_q;
    else if (sel_val)       bus_rdata = cnt_view;
    else if (sel_ctrl)      bus_rdata = CNT_W'(ctrl_q);
    else if (sel_raw)       bus_rdata = CNT_W'(raw_q);
    else if (sel_mis)       bus_rdata = CNT_W'(irq);
  end

  // R6: reaching zero always leaves the raw flag set
  a_r6_flag_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> raw_q);

  // R5: a clear write without a collision drops the flag
  a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !zero_evt) |=> !raw_q);

  // R11: a deferred load write leaves the count where it is, absent a tick
  a_r11_bg_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (bg_we && !zero_evt && !ctrl_q.enable) |=> $stable(cnt_view));

endmodule

// File: rtl/dtm_timer.sv
module dtm_timer
  import dtm_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned SHIFT_A  = 4,
  parameter int unsigned SHIFT_B  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] ADDR_VALUE = ADDR_W'(IDX_VALUE * 4);

  logic             rst_ni;
  ctrl_t            ctrl_q;
  ctrl_t            ctrl_d;
  logic [CNT_W-1:0] limit_d;
  logic             ctrl_we;
  logic             load_req;
  logic             tick;
  logic [CNT_W-1:0] cnt_view;
  logic             zero_evt;
  logic             free_run;

  assign free_run = ~ctrl_d.oneshot & ~ctrl_d.periodic;

  dtm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ni)
  );

  dtm_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_ni),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .cnt_view  (cnt_view),
    .zero_evt  (zero_evt),
    .ctrl_q    (ctrl_q),
    .ctrl_d    (ctrl_d),
    .limit_d   (limit_d),
    .ctrl_we   (ctrl_we),
    .load_req  (load_req),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  dtm_prescaler #(.SHIFT_A(SHIFT_A), .SHIFT_B(SHIFT_B)) u_pre (
    .clk     (clk),
    .rst_n   (rst_ni),
    .run     (ctrl_q.enable),
    .restart (ctrl_we),
    .psel    (ctrl_q.psel),
    .tick    (tick)
  );

  dtm_counter #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_ni),
    .tick     (tick),
    .load_req (load_req),
    .wide     (ctrl_d.wide),
    .oneshot  (ctrl_d.oneshot),
    .free_run (free_run),
    .limit    (limit_d),
    .cnt_view (cnt_view),
    .zero_evt (zero_evt)
  );

  // R2: writes to the count slot do not move the count
  a_r2_value_write_ignored: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_we && bus_addr == ADDR_VALUE && !tick) |=> $stable(cnt_view));

  // R12: with the timer disabled and no load, the count is frozen
  a_r12_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ctrl_q.enable && !load_req) |=> $stable(cnt_view) || $past(ctrl_we));

endmodule

// File: tb/dtm_timer_tb.sv
`timescale 1ns/10ps
module dtm_timer_tb;

  localparam logic [5:0] A_LOAD = 6'h00, A_VAL = 6'h04, A_CTRL = 6'h08,
                         A_CLR = 6'h0C, A_RAW = 6'h10, A_MIS = 6'h14,
                         A_BG = 6'h18, A_BAD = 6'h1C, A_TOP = 6'h3C, A_MIS_AL = 6'h01;
  localparam logic [31:0] EN = 32'h80, PER = 32'h40, IE = 32'h20, WIDE = 32'h02,
                          OS = 32'h01, D16 = 32'h04, D256 = 32'h08, D3 = 32'h0C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dtm_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    bus_addr = a;
    #0.1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", A_CTRL, 32'h20);
    rd_chk("R1 count", A_VAL, 32'h0);
    rd_chk("R1 limit", A_LOAD, 32'h0);
    rd_chk("R1 raw", A_RAW, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_map;
    wr(A_CTRL, 32'h1234_5662);             // periodic, wide, disabled
    rd_chk("R2 ctrl low byte", A_CTRL, 32'h62);
    wr(A_LOAD, 32'hA5);
    wr(A_VAL, 32'h55);
    rd_chk("R2 value write ignored", A_VAL, 32'hA5);
    wr(A_BAD, 32'h77);
    wr(A_MIS_AL, 32'h77);
    rd_chk("R2 unmapped write", A_LOAD, 32'hA5);
    rd_chk("R2 unmapped read", A_BAD, 32'h0);
    rd_chk("R2 top read", A_TOP, 32'h0);
    rd_chk("R2 misaligned read", A_MIS_AL, 32'h0);
  endtask

  task automatic t_periodic;
    wr(A_CTRL, PER | IE | WIDE);
    wr(A_LOAD, 32'd5);
    rd_chk("R10 immediate load", A_VAL, 32'd5);
    wr(A_CTRL, EN | PER | IE | WIDE);
    rd_chk("R12 enable reload", A_VAL, 32'd5);
    wt(4);
    rd_chk("R6 count 1", A_VAL, 32'd1);
    rd_chk("R6 raw not yet", A_RAW, 32'd0);
    wt(1);
    rd_chk("R6 count 0", A_VAL, 32'd0);
    rd_chk("R6 raw set", A_RAW, 32'd1);
    rd_chk("R4 masked", A_MIS, 32'd1);
    chk("R4 irq high", {31'b0, irq}, 32'd1);
    wt(1);
    rd_chk("R8 reload", A_VAL, 32'd5);
    wr(A_CLR, 32'hDEAD_BEEF);
    rd_chk("R5 cleared", A_RAW, 32'd0);
    chk("R5 irq low", {31'b0, irq}, 32'd0);
    wr(A_CTRL, EN | PER | WIDE);
    wt(5);
    rd_chk("R4 raw no ie", A_RAW, 32'd1);
    rd_chk("R4 masked no ie", A_MIS, 32'd0);
    chk("R4 irq no ie", {31'b0, irq}, 32'd0);
    wr(A_CTRL, PER | WIDE);               // disable: frozen at 5
    wt(7);
    rd_chk("R12 frozen", A_VAL, 32'd5);
    wr(A_CLR, 32'h0);
  endtask

  task automatic t_oneshot;
    wr(A_CTRL, OS | IE | WIDE);
    wr(A_LOAD, 32'd3);
    wr(A_CTRL, EN | OS | IE | WIDE);
    wt(3);
    rd_chk("R7 reached zero", A_VAL, 32'd0);
    rd_chk("R7 flag", A_RAW, 32'd1);
    wr(A_CLR, 32'h1);
    wt(10);
    rd_chk("R7 holds", A_VAL, 32'd0);
    rd_chk("R7 no refire", A_RAW, 32'd0);
    wr(A_LOAD, 32'd2);
    rd_chk("R10 rearm", A_VAL, 32'd2);
    wt(2);
    rd_chk("R7 second shot", A_RAW, 32'd1);
    wr(A_CTRL, IE);
    wr(A_CLR, 32'h0);
  endtask

  task automatic t_free;
    wr(A_LOAD, 32'd7);                    // ctrl = IE: free, 16-bit
    rd_chk("R9 load ignored", A_VAL, 32'h0000_FFFF);
    rd_chk("R9 limit kept", A_LOAD, 32'd7);
    wr(A_CTRL, EN | IE | WIDE);
    rd_chk("R9 wide all ones", A_VAL, 32'hFFFF_FFFF);
    wt(3);
    rd_chk("R9 wide counting", A_VAL, 32'hFFFF_FFFC);
    wr(A_CTRL, IE);
    wr(A_CLR, 32'h0);
    wr(A_CTRL, EN | IE);
    rd_chk("R9 narrow start", A_VAL, 32'h0000_FFFF);
    wt(65534);
    rd_chk("R9 near wrap", A_VAL, 32'd1);
    wt(1);
    rd_chk("R6 free zero", A_RAW, 32'd1);
    wt(1);
    rd_chk("R9 wrap reload", A_VAL, 32'h0000_FFFF);
    wr(A_CTRL, IE);
    wr(A_CLR, 32'h0);
  endtask

  task automatic t_narrow;
    wr(A_CTRL, PER | IE);
    wr(A_LOAD, 32'h0001_2345);
    rd_chk("R13 upper zero", A_VAL, 32'h0000_2345);
    rd_chk("R13 limit full", A_LOAD, 32'h0001_2345);
  endtask

  task automatic t_bgload;
    wr(A_CTRL, PER | IE | WIDE);
    wr(A_LOAD, 32'd4);
    wr(A_CTRL, EN | PER | IE | WIDE);
    wt(1);
    wr(A_BG, 32'd9);
    rd_chk("R11 count undisturbed", A_VAL, 32'd2);
    rd_chk("R11 readback load", A_LOAD, 32'd9);
    rd_chk("R11 readback bg", A_BG, 32'd9);
    wt(2);
    rd_chk("R11 zero", A_VAL, 32'd0);
    wt(1);
    rd_chk("R11 new limit used", A_VAL, 32'd9);
    wr(A_CTRL, PER | IE | WIDE);
    wr(A_CLR, 32'h0);
  endtask

  task automatic t_prescale;
    wr(A_LOAD, 32'd10);
    wr(A_CTRL, EN | PER | IE | WIDE | D16);
    wt(15);
    rd_chk("R3 div16 hold", A_VAL, 32'd10);
    wt(1);
    rd_chk("R3 div16 first", A_VAL, 32'd9);
    wt(16);
    rd_chk("R3 div16 second", A_VAL, 32'd8);
    wr(A_CTRL, EN | PER | IE | WIDE | D256);
    wt(255);
    rd_chk("R3 div256 hold", A_VAL, 32'd10);
    wt(1);
    rd_chk("R3 div256 first", A_VAL, 32'd9);
    wr(A_CTRL, EN | PER | IE | WIDE | D3);
    wt(1);
    rd_chk("R3 sel3 every clock", A_VAL, 32'd9);
    wr(A_CTRL, PER | IE | WIDE);
  endtask

  initial begin
    #600000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    wt(3);
    rst_n = 1'b1;
    wt(3);
    t_reset();
    t_map();
    t_periodic();
    t_oneshot();
    t_free();
    t_narrow();
    t_bgload();
    t_prescale();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule